// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the rotation period of two fans. Each fan drives a tachometer pulse train into the block. A shared reference tick at 32.768 kHz is applied as a one-cycle enable pulse in the system clock domain. For each fan the tick is divided by a programmable factor of 1, 2, 4 or 8. The block counts the divided ticks between two consecutive rising edges of the fan's tach signal, after that signal has been synchronised. The result is held in an 8-bit count register per fan. A slow fan therefore gives a large count.

Each latched count is compared with a programmable 8-bit limit for that fan. A count above the limit means the fan has slowed too far. In that case two sticky flags are raised for the fan: a power-management event flag and a system-management interrupt flag. Each flag stays set until the host writes a one to that flag's clear input.

A fan that stops sends no closing edge. Its counter then stops at 255, and that value is latched as a stall reading. The divisor for each fan comes from its own two-bit field in a shared 8-bit control word.

Top module: `fan_tach_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every count register reads 0 and every flag reads 0.
- R2: Each tach input passes through a two-flop synchroniser and then a rising-edge detector. The first rising edge after reset only starts a measurement and leaves the count register unchanged.
- R3: Fan index 0 takes its divisor from `fan_ctrl[7:6]` and fan index 1 from `fan_ctrl[5:4]`. The field encodes the divisor as 00 = 1, 01 = 2, 10 = 4 and 11 = 8. Every rising edge resets the divider phase, so after n reference ticks the counter holds floor(n / divisor).
- R4: On each rising edge after the first, the number of divided ticks since the previous edge is loaded into that fan's count register (`tach_count[8*i+7:8*i]` for fan i). The counter then restarts from 0.
- R5: If no edge arrives, the counter stops at 255 and does not wrap. The value 255 is loaded into the count register when the counter reaches it.
- R6: When a loaded value is strictly greater than the fan's limit (`tach_limit[8*i+7:8*i]`), both `pme_flag[i]` and `smi_flag[i]` are set. A value equal to the limit or below it sets neither flag.
- R7: Both flags are sticky. A later value at or below the limit does not clear them. A one on `pme_clr[i]` clears only `pme_flag[i]`, and a one on `smi_clr[i]` clears only `smi_flag[i]`.
- R8: The fans are independent. Edges, ticks and clears on one fan do not change the count register or the flags of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per 32.768 kHz reference period |
| tach_in | input | 2 | Asynchronous tach inputs, bit i for fan i |
| fan_ctrl | input | 8 | Shared control word holding the divisor fields |
| tach_limit | input | 16 | Per-fan 8-bit speed limits, fan i in bits 8*i+7:8*i |
| pme_clr | input | 2 | Write-one clear of the power-management flag for each fan |
| smi_clr | input | 2 | Write-one clear of the interrupt flag for each fan |
| tach_count | output | 16 | Per-fan latched period counts, fan i in bits 8*i+7:8*i |
| pme_flag | output | 2 | Sticky power-management event flags |
| smi_flag | output | 2 | Sticky system-management interrupt flags |

## Verification
On every cycle the embedded properties check several behaviours. The divider emits a tick only on a reference pulse. A detected rising edge always comes from a synchronised high level on the pin. The counter restarts and loads its count at each closing edge, and it neither wraps nor moves backward between edges. An over-limit load raises both flags, and the flags stay set until cleared. Other points can be shown only by the bench scenarios: the exact count for each divisor, the choice of control field for each fan, the strict greater-than comparison at the limit, arming on the first edge, stall saturation after a long run of ticks, and the isolation between fans.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;

    localparam int CNT_W  = 8;
    localparam int PRE_W  = 3;
    localparam int FLD_W  = 2;
    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        DIV_1 = 2'b00,
        DIV_2 = 2'b01,
        DIV_4 = 2'b10,
        DIV_8 = 2'b11
    } div_sel_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } meas_phase_e;

    typedef struct packed {
        logic pme;
        logic smi;
    } alarm_flags_t;

    // Low bits of the divider phase that must all be ones for a tick to pass
    function automatic logic [PRE_W-1:0] div_mask(div_sel_e d);
        logic [PRE_W-1:0] m;
        case (d)
            DIV_1:   m = 3'b000;
            DIV_2:   m = 3'b001;
            DIV_4:   m = 3'b011;
            default: m = 3'b111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tach_in,
    output logic rise
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sh_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[TOP-1:0], tach_in};
            prev_q <= sh_q[TOP];
        end
    end

    assign rise = sh_q[TOP] & ~prev_q;

    // R2: an edge is only reported after the pin was high SYNC_STAGES clocks earlier
    a_r2_rise_from_pin: assert property (@(posedge clk) disable iff (rst)
        rise |-> $past(tach_in, SYNC_STAGES));

endmodule

// File: rtl/fan_tach_prescaler.sv
module fan_tach_prescaler
    import fan_tach_pkg::*;
#(
    parameter int PRE_W = fan_tach_pkg::PRE_W
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ref_tick,
    input  logic     restart,
    input  div_sel_e div,
    output logic     tick
);
    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    assign mask = PRE_W'(div_mask(div));
    assign tick = ref_tick && ((phase_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (ref_tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R3: a divided tick never appears without a reference pulse
    a_r3_tick_needs_ref: assert property (@(posedge clk) disable iff (rst)
        tick |-> ref_tick);

    // R3: a restart clears the divider phase
    a_r3_restart_phase: assert property (@(posedge clk) disable iff (rst)
        restart |=> phase_q == '0);

endmodule

// File: rtl/fan_tach_counter.sv
module fan_tach_counter
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = fan_tach_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             tick,
    output logic [CNT_W-1:0] count_q,
    output logic             latch_en,
    output logic [CNT_W-1:0] latch_val
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    meas_phase_e      phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             close_hit;
    logic             sat_hit;

    assign close_hit = (phase_q == PH_RUN) && rise;
    assign sat_hit   = (phase_q == PH_RUN) && !rise && tick && (cnt_q == CNT_MAX - 1'b1);
    assign latch_en  = close_hit || sat_hit;
    assign latch_val = close_hit ? cnt_q : CNT_MAX;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            count_q <= '0;
        end else begin
            if (rise) begin
                phase_q <= PH_RUN;
                cnt_q   <= '0;
            end else if ((phase_q == PH_RUN) && tick && (cnt_q != CNT_MAX)) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (latch_en) begin
                count_q <= latch_val;
            end
        end
    end

    // R4: a closing edge loads the running count and restarts it
    a_r4_latch: assert property (@(posedge clk) disable iff (rst)
        close_hit |=> (count_q == $past(cnt_q)) && (cnt_q == '0));

    // R4: between edges the running count never moves backward
    a_r4_monotone: assert property (@(posedge clk) disable iff (rst)
        !rise |=> cnt_q >= $past(cnt_q));

    // R5: once at the top the counter holds until an edge
    a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX) && !rise |=> cnt_q == CNT_MAX);

    // R2: while idle the count register is not loaded
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE) |=> $stable(count_q));

endmodule

// File: rtl/fan_tach_alarm.sv
module fan_tach_alarm
    import fan_tach_pkg::*;
#(
    parameter int CNT_W = fan_tach_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_en,
    input  logic [CNT_W-1:0] latch_val,
    input  logic [CNT_W-1:0] limit,
    input  logic             pme_clr,
    input  logic             smi_clr,
    output alarm_flags_t     flags_q
);
    logic trip;

    assign trip = latch_en && (latch_val > limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.pme <= trip | (flags_q.pme & ~pme_clr);
            flags_q.smi <= trip | (flags_q.smi & ~smi_clr);
        end
    end

    // R6: an over-limit load raises both flags
    a_r6_trip_both: assert property (@(posedge clk) disable iff (rst)
        (latch_en && (latch_val > limit)) |=> flags_q.pme && flags_q.smi);

    // R7: flags only drop through their own clear
    a_r7_pme_sticky: assert property (@(posedge clk) disable iff (rst)
        flags_q.pme && !pme_clr |=> flags_q.pme);
    a_r7_smi_sticky: assert property (@(posedge clk) disable iff (rst)
        flags_q.smi && !smi_clr |=> flags_q.smi);

endmodule

// File: rtl/fan_tach_top.sv
module fan_tach_top
    import fan_tach_pkg::*;
#(
    parameter int NUM_FANS    = 2,
    parameter int CNT_W       = fan_tach_pkg::CNT_W,
    parameter int PRE_W       = fan_tach_pkg::PRE_W,
    parameter int CTRL_W      = fan_tach_pkg::CTRL_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ref_tick,
    input  logic [NUM_FANS-1:0]       tach_in,
    input  logic [CTRL_W-1:0]         fan_ctrl,
    input  logic [NUM_FANS*CNT_W-1:0] tach_limit,
    input  logic [NUM_FANS-1:0]       pme_clr,
    input  logic [NUM_FANS-1:0]       smi_clr,
    output logic [NUM_FANS*CNT_W-1:0] tach_count,
    output logic [NUM_FANS-1:0]       pme_flag,
    output logic [NUM_FANS-1:0]       smi_flag
);
    localparam int FLD_W    = fan_tach_pkg::FLD_W;
    localparam int USED_W   = FLD_W * NUM_FANS;
    localparam int SPARE_W  = CTRL_W - USED_W;

    generate
        if (SPARE_W > 0) begin : g_spare
            logic unused_ctrl_bits;
            assign unused_ctrl_bits = ^fan_ctrl[SPARE_W-1:0];
        end

        for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
            div_sel_e         div;
            logic             rise;
            logic             tick;
            logic             latch_en;
            logic [CNT_W-1:0] latch_val;
            logic [CNT_W-1:0] count_q;
            alarm_flags_t     flags;

            // Fan 0 owns the top field, each following fan the next lower one
            assign div = div_sel_e'(fan_ctrl[CTRL_W-1-FLD_W*g -: FLD_W]);

            fan_tach_sync #(
                .SYNC_STAGES(SYNC_STAGES)
            ) u_sync (
                .clk     (clk),
                .rst     (rst),
                .tach_in (tach_in[g]),
                .rise    (rise)
            );

            fan_tach_prescaler #(
                .PRE_W(PRE_W)
            ) u_pre (
                .clk      (clk),
                .rst      (rst),
                .ref_tick (ref_tick),
                .restart  (rise),
                .div      (div),
                .tick     (tick)
            );

            fan_tach_counter #(
                .CNT_W(CNT_W)
            ) u_cnt (
                .clk       (clk),
                .rst       (rst),
                .rise      (rise),
                .tick      (tick),
                .count_q   (count_q),
                .latch_en  (latch_en),
                .latch_val (latch_val)
            );

            fan_tach_alarm #(
                .CNT_W(CNT_W)
            ) u_alarm (
                .clk       (clk),
                .rst       (rst),
                .latch_en  (latch_en),
                .latch_val (latch_val),
                .limit     (tach_limit[CNT_W*g +: CNT_W]),
                .pme_clr   (pme_clr[g]),
                .smi_clr   (smi_clr[g]),
                .flags_q   (flags)
            );

            assign tach_count[CNT_W*g +: CNT_W] = count_q;
            assign pme_flag[g] = flags.pme;
            assign smi_flag[g] = flags.smi;
        end
    endgenerate

endmodule

// File: tb/tb_fan_tach_top.sv
`timescale 1ns/1ps
module tb_fan_tach_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [1:0]  tach_in = 2'b00;
    logic [7:0]  fan_ctrl = 8'h00;
    logic [15:0] tach_limit = 16'h0000;
    logic [1:0]  pme_clr = 2'b00;
    logic [1:0]  smi_clr = 2'b00;
    logic [15:0] tach_count;
    logic [1:0]  pme_flag;
    logic [1:0]  smi_flag;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 1'b0;

    always #2 clk = ~clk;

    fan_tach_top dut (
        .clk        (clk),
        .rst        (rst),
        .ref_tick   (ref_tick),
        .tach_in    (tach_in),
        .fan_ctrl   (fan_ctrl),
        .tach_limit (tach_limit),
        .pme_clr    (pme_clr),
        .smi_clr    (smi_clr),
        .tach_count (tach_count),
        .pme_flag   (pme_flag),
        .smi_flag   (smi_flag)
    );

    typedef struct packed {
        logic [1:0] div;
        logic [9:0] nref;
        logic [7:0] limit;
        logic [7:0] exp_cnt;
        logic       exp_alarm;
    } vec_t;

    // expected count = floor(nref / divisor), alarm = count > limit
    localparam vec_t VEC [0:6] = '{
        '{2'b00, 10'd10,  8'd20, 8'd10,  1'b0},
        '{2'b01, 10'd11,  8'd4,  8'd5,   1'b1},
        '{2'b10, 10'd17,  8'd4,  8'd4,   1'b0},
        '{2'b11, 10'd40,  8'd4,  8'd5,   1'b1},
        '{2'b00, 10'd0,   8'd0,  8'd0,   1'b0},
        '{2'b11, 10'd7,   8'd0,  8'd0,   1'b0},
        '{2'b01, 10'd200, 8'd99, 8'd100, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic refs(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) ref_tick = 1'b1;
            @(negedge clk) ref_tick = 1'b0;
        end
    endtask

    // lower the tach, send n reference pulses, raise it and let the load settle
    task automatic period(input int ch, input int n);
        @(negedge clk) tach_in[ch] = 1'b0;
        cyc(4);
        refs(n);
        @(negedge clk) tach_in[ch] = 1'b1;
        cyc(4);
    endtask

    task automatic clr_all();
        @(negedge clk) begin pme_clr = 2'b11; smi_clr = 2'b11; end
        @(negedge clk) begin pme_clr = 2'b00; smi_clr = 2'b00; end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        cyc(4);
        chk("R1 count in reset", {16'd0, tach_count}, 32'd0);
        chk("R1 pme in reset", {30'd0, pme_flag}, 32'd0);
        @(negedge clk) rst = 1'b0;
        chk("R1 smi after reset", {30'd0, smi_flag}, 32'd0);

        // R2: first edge arms only
        refs(3);
        @(negedge clk) tach_in[0] = 1'b1;
        cyc(4);
        chk("R2 first edge leaves count", {24'd0, tach_count[7:0]}, 32'd0);

        // R3 R4 R6: table walk on fan 0
        for (int i = 0; i < 7; i++) begin
            fan_ctrl[7:6]    = VEC[i].div;
            tach_limit[7:0]  = VEC[i].limit;
            clr_all();
            period(0, int'(VEC[i].nref));
            chk($sformatf("R3 R4 vec%0d count", i), {24'd0, tach_count[7:0]}, {24'd0, VEC[i].exp_cnt});
            chk($sformatf("R6 vec%0d pme", i), {31'd0, pme_flag[0]}, {31'd0, VEC[i].exp_alarm});
            chk($sformatf("R6 vec%0d smi", i), {31'd0, smi_flag[0]}, {31'd0, VEC[i].exp_alarm});
        end

        // R8: fan 1 untouched by fan 0 activity
        chk("R8 fan1 count idle", {24'd0, tach_count[15:8]}, 32'd0);
        chk("R8 fan1 flags idle", {30'd0, pme_flag[1], smi_flag[1]}, 32'd0);

        // R3: fan 1 reads bits 5:4 (01 = /2) while fan 0 field is 11
        fan_ctrl = 8'b1101_0000;
        tach_limit[15:8] = 8'd3;
        @(negedge clk) tach_in[1] = 1'b1;
        cyc(4);
        period(1, 9);
        chk("R3 fan1 divisor field", {24'd0, tach_count[15:8]}, 32'd4);
        chk("R6 fan1 pme over limit", {31'd0, pme_flag[1]}, 32'd1);
        chk("R8 fan0 count kept", {24'd0, tach_count[7:0]}, 32'd100);

        // R7: sticky across an in-limit load, separate clears
        period(1, 4);
        chk("R7 fan1 count in limit", {24'd0, tach_count[15:8]}, 32'd2);
        chk("R7 pme sticky", {31'd0, pme_flag[1]}, 32'd1);
        chk("R7 smi sticky", {31'd0, smi_flag[1]}, 32'd1);
        @(negedge clk) pme_clr = 2'b10;
        @(negedge clk) pme_clr = 2'b00;
        cyc(1);
        chk("R7 pme cleared", {31'd0, pme_flag[1]}, 32'd0);
        chk("R7 smi kept", {31'd0, smi_flag[1]}, 32'd1);
        chk("R8 fan0 pme unaffected", {31'd0, pme_flag[0]}, 32'd1);
        @(negedge clk) smi_clr = 2'b10;
        @(negedge clk) smi_clr = 2'b00;
        cyc(1);
        chk("R7 smi cleared", {31'd0, smi_flag[1]}, 32'd0);

        // R5: stalled fan 0 saturates at 255 and alarms
        fan_ctrl[7:6] = 2'b00;
        tach_limit[7:0] = 8'd100;
        clr_all();
        @(negedge clk) tach_in[0] = 1'b0;
        refs(260);
        cyc(2);
        chk("R5 stall count", {24'd0, tach_count[7:0]}, 32'd255);
        chk("R5 stall pme", {31'd0, pme_flag[0]}, 32'd1);
        chk("R5 stall smi", {31'd0, smi_flag[0]}, 32'd1);

        // R1: reset again clears everything
        @(negedge clk) rst = 1'b1;
        cyc(2);
        chk("R1 count cleared", {16'd0, tach_count}, 32'd0);
        chk("R1 flags cleared", {28'd0, pme_flag, smi_flag}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule